// File: doc/BRIEF.md
# Keyed Watchdog Timer with Posted Register Writes

This block is a watchdog peripheral with two clocks. A fast bus clock serves a simple register interface, and a slow functional clock, nominally 32.768 kHz, drives the counting logic. The counter counts upward from a programmed load value. When it wraps past all ones while armed, the block pulses a reset output and reloads itself. Software keeps the system alive by writing the trigger register. Each write must carry a value different from the previous one, so firmware normally alternates a pattern and its inverse.

Arming and disarming each need an ordered pair of key words written to one register, so a stray write cannot change the state. Every configuration write is posted. The bus side holds the written value, raises a pending bit for that register, and passes the value into the functional domain through a toggle handshake. The pending bit drops when the acknowledge returns. Counter, armed and expiry state come back to the bus domain as a snapshot that is refreshed on every functional-clock cycle. The functional clock must run at no more than a quarter of the bus clock rate.

Top module: `wdt_timer`

## Requirements
- R1: After reset these all read zero: the counter (offset 0x28), the load value (0x2C), the pending status (0x34) and the status (0x14). The watchdog is disarmed and `wdt_rst_o` is low.
- R2: Reads return the revision constant 0x00000010 at offset 0x00. Offset 0x24 returns the control value. Offset 0x14 returns the status, with bit 0 as the sticky expiry flag and bit 1 as armed. Offset 0x28 returns the live counter within a few bus cycles of a functional-clock edge.
- R3: Writing 0x0000BBBB and then, as the very next start/stop write, 0x00004444 to offset 0x48 arms the watchdog.
- R4: Writing 0x0000AAAA and then, as the very next start/stop write, 0x00005555 to offset 0x48 disarms it.
- R5: Any other word in the second position abandons the sequence and is discarded. A stray or mismatched pair neither arms nor disarms the watchdog.
- R6: Pending status bit positions are: bit 0 control, bit 2 load, bit 3 trigger, bit 4 start/stop. Each bit reads 1 on the cycle after the write and clears once the value has landed. A write to a register whose pending bit is set is dropped.
- R7: Control bit 5 enables the prescaler and bits 4:2 hold an exponent P. With the prescaler enabled the counter advances once every 2^P functional cycles; with it disabled the counter advances every cycle, whatever P is.
- R8: When the counter wraps from all ones while armed, `wdt_rst_o` pulses for exactly one functional cycle, the counter reloads from the load value and status bit 0 sets and stays set. Consecutive expiries with load L are spaced (2^32 − L)·2^P functional cycles apart.
- R9: A trigger write whose value differs from the last trigger value reloads the counter from the load value and restarts the prescale phase. Repeating the same value has no effect. The last trigger value resets to 0.
- R10: While disarmed the counter holds its value, but a trigger reload still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus-side clock |
| fclk_i | input | 1 | Functional counting clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| bus_sel_i | input | 1 | Register access select |
| bus_we_i | input | 1 | Write enable, qualified by select |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current offset, combinational |
| wdt_rst_o | output | 1 | One-functional-cycle reset request on expiry |

## Verification
If the prescale phase or the reload point is off by one, the spacing between two reset pulses moves by whole ticks. The bench measures that spacing in functional cycles across every exponent, so such a fault shows on the second pulse. A broken key sequencer shows in the armed status bit within a few cycles of the second key word. A broken handshake leaves a pending bit stuck, or lets a dropped write reach the load value, which then appears in the counter after the next reload. A trigger comparison that is too eager or too strict shows as a reset pulse that appears, or fails to appear, inside a window of regular kicks.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] OFS_REV    = 8'h00;
  localparam logic [7:0] OFS_STAT   = 8'h14;
  localparam logic [7:0] OFS_CTRL   = 8'h24;
  localparam logic [7:0] OFS_CNT    = 8'h28;
  localparam logic [7:0] OFS_LOAD   = 8'h2C;
  localparam logic [7:0] OFS_TRIG   = 8'h30;
  localparam logic [7:0] OFS_PEND   = 8'h34;
  localparam logic [7:0] OFS_KEY    = 8'h48;

  localparam logic [31:0] REV_ID    = 32'h0000_0010;
  localparam logic [31:0] KEY_ARM_A = 32'h0000_BBBB;
  localparam logic [31:0] KEY_ARM_B = 32'h0000_4444;
  localparam logic [31:0] KEY_DIS_A = 32'h0000_AAAA;
  localparam logic [31:0] KEY_DIS_B = 32'h0000_5555;

  typedef enum logic [1:0] {
    KS_IDLE,
    KS_ARM,
    KS_DIS
  } key_st_e;
endpackage

// File: rtl/wdt_post_chan.sv
module wdt_post_chan #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         fclk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] hold_o,
  output logic         pend_o,
  output logic [W-1:0] f_data_o,
  output logic         f_stb_o
);
  logic [W-1:0] hold_q;
  logic         req_q;
  logic [1:0]   ack_sync_q;
  logic [2:0]   req_sync_q;

  // bus side: capture and toggle request; writes while in flight are dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      req_q  <= 1'b0;
    end else if (wr_i && !pend_o) begin
      hold_q <= wdata_i;
      req_q  <= ~req_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_sync_q <= '0;
    else         ack_sync_q <= {ack_sync_q[0], req_sync_q[2]};
  end

  // functional side: 2-flop sync plus edge detect; third flop is the ack
  always_ff @(posedge fclk_i or negedge rst_ni) begin
    if (!rst_ni) req_sync_q <= '0;
    else         req_sync_q <= {req_sync_q[1:0], req_q};
  end

  assign pend_o   = req_q ^ ack_sync_q[1];
  assign hold_o   = hold_q;
  assign f_data_o = hold_q;
  assign f_stb_o  = req_sync_q[1] ^ req_sync_q[2];

  AST_PEND_DROPS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && pend_o) |=> $stable(hold_q)); // R6
endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
  import wdt_pkg::*;
(
  input  logic        fclk_i,
  input  logic        rst_ni,
  input  logic        stb_i,
  input  logic [31:0] word_i,
  output logic        arm_o,
  output logic        disarm_o
);
  key_st_e st_q;

  always_ff @(posedge fclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= KS_IDLE;
    end else if (stb_i) begin
      unique case (st_q)
        KS_IDLE: begin
          if (word_i == KEY_ARM_A)      st_q <= KS_ARM;
          else if (word_i == KEY_DIS_A) st_q <= KS_DIS;
        end
        default: st_q <= KS_IDLE;
      endcase
    end
  end

  assign arm_o    = stb_i && (st_q == KS_ARM) && (word_i == KEY_ARM_B);
  assign disarm_o = stb_i && (st_q == KS_DIS) && (word_i == KEY_DIS_B);

  AST_KEY_EXCLUSIVE: assert property (@(posedge fclk_i) disable iff (!rst_ni)
    !(arm_o && disarm_o)); // R5
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int CNT_W = 32,
  parameter int PTV_W = 3
) (
  input  logic             fclk_i,
  input  logic             rst_ni,
  input  logic             ctrl_stb_i,
  input  logic [PTV_W:0]   ctrl_d_i,
  input  logic             load_stb_i,
  input  logic [CNT_W-1:0] load_d_i,
  input  logic             trig_stb_i,
  input  logic [31:0]      trig_d_i,
  input  logic             key_stb_i,
  input  logic [31:0]      key_d_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             exp_o,
  output logic             rst_o
);
  localparam int PRE_W = (1 << PTV_W) - 1;

  logic [PTV_W:0]   ctrl_q;
  logic [CNT_W-1:0] load_q, cnt_q;
  logic [31:0]      last_trig_q;
  logic [PRE_W-1:0] pre_q, pre_mask;
  logic             run_q, exp_q, rst_q;
  logic             arm, disarm, reload, tick;

  wdt_keyseq u_keyseq (
    .fclk_i  (fclk_i),
    .rst_ni  (rst_ni),
    .stb_i   (key_stb_i),
    .word_i  (key_d_i),
    .arm_o   (arm),
    .disarm_o(disarm)
  );

  assign reload   = trig_stb_i && (trig_d_i != last_trig_q);
  assign pre_mask = ~({PRE_W{1'b1}} << ctrl_q[PTV_W-1:0]);
  assign tick     = !ctrl_q[PTV_W] || ((pre_q & pre_mask) == pre_mask);

  always_ff @(posedge fclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      load_q      <= '0;
      last_trig_q <= '0;
      run_q       <= 1'b0;
    end else begin
      if (ctrl_stb_i) ctrl_q <= ctrl_d_i;
      if (load_stb_i) load_q <= load_d_i;
      if (trig_stb_i) last_trig_q <= trig_d_i;
      if (arm)         run_q <= 1'b1;
      else if (disarm) run_q <= 1'b0;
    end
  end

  always_ff @(posedge fclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pre_q <= '0;
      exp_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_q <= 1'b0;
      if (reload) begin
        cnt_q <= load_q;
        pre_q <= '0;
      end else if (!run_q) begin
        pre_q <= '0;
      end else if (tick) begin
        if (&cnt_q) begin
          cnt_q <= load_q;
          pre_q <= '0;
          rst_q <= 1'b1;
          exp_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          pre_q <= pre_q + 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
  assign exp_o = exp_q;
  assign rst_o = rst_q;

  AST_RST_ONE_CYCLE: assert property (@(posedge fclk_i) disable iff (!rst_ni)
    rst_q |=> !rst_q); // R8
  AST_WRAP_FROM_ONES: assert property (@(posedge fclk_i) disable iff (!rst_ni)
    rst_q |-> &$past(cnt_q)); // R8
  AST_EXP_STICKY: assert property (@(posedge fclk_i) disable iff (!rst_ni)
    exp_q |=> exp_q); // R8
  AST_STOPPED_HOLDS: assert property (@(posedge fclk_i) disable iff (!rst_ni)
    (!run_q && !reload) |=> $stable(cnt_q)); // R10
  AST_SAME_TRIG_NO_RELOAD: assert property (@(posedge fclk_i) disable iff (!rst_ni)
    (!run_q && trig_stb_i && trig_d_i == last_trig_q) |=> $stable(cnt_q)); // R9
  AST_ARM_NEEDS_KEY: assert property (@(posedge fclk_i) disable iff (!rst_ni)
    $rose(run_q) |-> $past(key_stb_i)); // R3
  AST_DISARM_NEEDS_KEY: assert property (@(posedge fclk_i) disable iff (!rst_ni)
    $fell(run_q) |-> $past(key_stb_i)); // R4
endmodule

// File: rtl/wdt_snap_sync.sv
module wdt_snap_sync #(
  parameter int W = 34
) (
  input  logic         clk_i,
  input  logic         fclk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] f_val_i,
  output logic [W-1:0] val_o
);
  logic [W-1:0] snap_q, val_q;
  logic         tog_q;
  logic [2:0]   tog_sync_q;

  // functional side publishes every cycle; bus side copies on each toggle edge
  always_ff @(posedge fclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0;
      tog_q  <= 1'b0;
    end else begin
      snap_q <= f_val_i;
      tog_q  <= ~tog_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_sync_q <= '0;
      val_q      <= '0;
    end else begin
      tog_sync_q <= {tog_sync_q[1:0], tog_q};
      if (tog_sync_q[1] ^ tog_sync_q[2]) val_q <= snap_q;
    end
  end

  assign val_o = val_q;
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PTV_W = 3
) (
  input  logic        clk_i,
  input  logic        fclk_i,
  input  logic        rst_ni,
  input  logic        bus_sel_i,
  input  logic        bus_we_i,
  input  logic [7:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        wdt_rst_o
);
  localparam int CTRL_W = PTV_W + 1;
  localparam int SNAP_W = CNT_W + 2;

  logic wr_ctrl, wr_load, wr_trig, wr_key;
  logic pend_ctrl, pend_load, pend_trig, pend_key;
  logic stb_ctrl, stb_load, stb_trig, stb_key;
  logic [CTRL_W-1:0] hold_ctrl, f_ctrl;
  logic [CNT_W-1:0]  hold_load, f_load;
  logic [31:0]       hold_trig, f_trig, hold_key, f_key;
  logic [CNT_W-1:0]  f_cnt;
  logic              f_run, f_exp;
  logic [SNAP_W-1:0] snap;

  wire bus_wr = bus_sel_i && bus_we_i;
  assign wr_ctrl = bus_wr && (bus_addr_i == OFS_CTRL);
  assign wr_load = bus_wr && (bus_addr_i == OFS_LOAD);
  assign wr_trig = bus_wr && (bus_addr_i == OFS_TRIG);
  assign wr_key  = bus_wr && (bus_addr_i == OFS_KEY);

  wdt_post_chan #(.W(CTRL_W)) u_ch_ctrl (
    .clk_i(clk_i), .fclk_i(fclk_i), .rst_ni(rst_ni), .wr_i(wr_ctrl),
    .wdata_i(bus_wdata_i[2 +: CTRL_W]), .hold_o(hold_ctrl), .pend_o(pend_ctrl),
    .f_data_o(f_ctrl), .f_stb_o(stb_ctrl));

  wdt_post_chan #(.W(CNT_W)) u_ch_load (
    .clk_i(clk_i), .fclk_i(fclk_i), .rst_ni(rst_ni), .wr_i(wr_load),
    .wdata_i(bus_wdata_i[CNT_W-1:0]), .hold_o(hold_load), .pend_o(pend_load),
    .f_data_o(f_load), .f_stb_o(stb_load));

  wdt_post_chan #(.W(32)) u_ch_trig (
    .clk_i(clk_i), .fclk_i(fclk_i), .rst_ni(rst_ni), .wr_i(wr_trig),
    .wdata_i(bus_wdata_i), .hold_o(hold_trig), .pend_o(pend_trig),
    .f_data_o(f_trig), .f_stb_o(stb_trig));

  wdt_post_chan #(.W(32)) u_ch_key (
    .clk_i(clk_i), .fclk_i(fclk_i), .rst_ni(rst_ni), .wr_i(wr_key),
    .wdata_i(bus_wdata_i), .hold_o(hold_key), .pend_o(pend_key),
    .f_data_o(f_key), .f_stb_o(stb_key));

  wdt_core #(.CNT_W(CNT_W), .PTV_W(PTV_W)) u_core (
    .fclk_i    (fclk_i),
    .rst_ni    (rst_ni),
    .ctrl_stb_i(stb_ctrl),
    .ctrl_d_i  (f_ctrl),
    .load_stb_i(stb_load),
    .load_d_i  (f_load),
    .trig_stb_i(stb_trig),
    .trig_d_i  (f_trig),
    .key_stb_i (stb_key),
    .key_d_i   (f_key),
    .cnt_o     (f_cnt),
    .run_o     (f_run),
    .exp_o     (f_exp),
    .rst_o     (wdt_rst_o)
  );

  wdt_snap_sync #(.W(SNAP_W)) u_snap (
    .clk_i (clk_i),
    .fclk_i(fclk_i),
    .rst_ni(rst_ni),
    .f_val_i({f_run, f_exp, f_cnt}),
    .val_o (snap)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      OFS_REV:  bus_rdata_o = REV_ID;
      OFS_STAT: bus_rdata_o[1:0] = snap[SNAP_W-1 -: 2];
      OFS_CTRL: bus_rdata_o[2 +: CTRL_W] = hold_ctrl;
      OFS_CNT:  bus_rdata_o[CNT_W-1:0] = snap[CNT_W-1:0];
      OFS_LOAD: bus_rdata_o[CNT_W-1:0] = hold_load;
      OFS_TRIG: bus_rdata_o = hold_trig;
      OFS_PEND: bus_rdata_o[4:0] = {pend_key, pend_trig, pend_load, 1'b0, pend_ctrl};
      OFS_KEY:  bus_rdata_o = hold_key;
      default:  bus_rdata_o = '0;
    endcase
  end

  AST_PEND_SET_AFTER_LOAD_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_load && !pend_load) |=> pend_load); // R6
endmodule

// File: tb/tb_wdt_timer.sv
module tb_wdt_timer;
  import wdt_pkg::*;

  logic        clk = 1'b0, fclk = 1'b0, rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wrst;

  int checks = 0, fails = 0;
  int fcyc = 0, rst_cnt = 0, last_rst = 0, prev_rst = 0;
  bit done = 1'b0;
  logic [31:0] trig_val = 32'h0000_1234;

  always #4 clk = ~clk;
  always #20 fclk = ~fclk;

  wdt_timer dut (
    .clk_i(clk), .fclk_i(fclk), .rst_ni(rst_n),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .wdt_rst_o(wrst)
  );

  always @(negedge fclk) begin
    fcyc++;
    if (wrst) begin
      prev_rst = last_rst;
      last_rst = fcyc;
      rst_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic br(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    br(OFS_PEND, v);
    while (v != 0) begin
      @(negedge clk);
      br(OFS_PEND, v);
    end
  endtask

  task automatic bwi(input logic [7:0] a, input logic [31:0] d);
    bw(a, d);
    wait_idle();
  endtask

  task automatic settle();
    repeat (4) @(negedge fclk);
    @(negedge clk);
  endtask

  task automatic kick();
    trig_val = ~trig_val;
    bwi(OFS_TRIG, trig_val);
  endtask

  task automatic arm();
    bwi(OFS_KEY, KEY_ARM_A);
    bwi(OFS_KEY, KEY_ARM_B);
  endtask

  task automatic disarm();
    bwi(OFS_KEY, KEY_DIS_A);
    bwi(OFS_KEY, KEY_DIS_B);
  endtask

  task automatic wait_pulses(input int n);
    int target;
    target = rst_cnt + n;
    while (rst_cnt < target) @(negedge fclk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    int base;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    br(OFS_CNT, v);  chk(v == 0, "R1 counter", v, 0);
    br(OFS_LOAD, v); chk(v == 0, "R1 load", v, 0);
    br(OFS_PEND, v); chk(v == 0, "R1 pending", v, 0);
    br(OFS_STAT, v); chk(v == 0, "R1 status", v, 0);
    chk(wrst == 1'b0, "R1 reset output", {31'd0, wrst}, 0);
    br(OFS_REV, v);  chk(v == 32'h10, "R2 revision", v, 32'h10);

    // R6 pending bit and dropped write
    bw(OFS_LOAD, 32'hFFFF_FFFB);
    br(OFS_PEND, v); chk(v == 32'h4, "R6 load pending bit2", v, 32'h4);
    bw(OFS_LOAD, 32'h0000_0001);
    wait_idle();
    br(OFS_LOAD, v); chk(v == 32'hFFFF_FFFB, "R6 dropped write", v, 32'hFFFF_FFFB);
    bw(OFS_CTRL, 32'h0);
    br(OFS_PEND, v); chk(v == 32'h1, "R6 ctrl pending bit0", v, 32'h1);
    wait_idle();
    bw(OFS_TRIG, trig_val);
    br(OFS_PEND, v); chk(v == 32'h8, "R6 trigger pending bit3", v, 32'h8);
    wait_idle();
    settle();
    br(OFS_CNT, v); chk(v == 32'hFFFF_FFFB, "R9 R10 reload while disarmed", v, 32'hFFFF_FFFB);

    // R3 arm, R8 expiry spacing and sticky flag
    bw(OFS_KEY, KEY_ARM_A);
    br(OFS_PEND, v); chk(v == 32'h10, "R6 key pending bit4", v, 32'h10);
    wait_idle();
    bwi(OFS_KEY, KEY_ARM_B);
    settle();
    br(OFS_STAT, v); chk(v[1] == 1'b1, "R3 armed", v, 32'h2);
    wait_pulses(2);
    chk(last_rst - prev_rst == 5, "R8 expiry interval", last_rst - prev_rst, 5);
    settle();
    br(OFS_STAT, v); chk(v[0] == 1'b1, "R8 expiry flag", v, 32'h3);

    // R4 disarm, R10 hold
    disarm();
    settle();
    br(OFS_STAT, v); chk(v == 32'h1, "R4 disarmed, R8 flag sticky", v, 32'h1);
    base = rst_cnt;
    br(OFS_CNT, v);
    repeat (30) @(negedge fclk);
    @(negedge clk);
    br(OFS_CNT, v2); chk(v2 == v, "R10 counter holds", v2, v);
    chk(rst_cnt == base, "R10 no expiry when disarmed", rst_cnt, base);

    // R5 broken sequences
    bwi(OFS_KEY, KEY_ARM_A);
    bwi(OFS_KEY, 32'h0000_1234);
    bwi(OFS_KEY, KEY_ARM_B);
    settle();
    br(OFS_STAT, v); chk(v[1] == 1'b0, "R5 stray word blocks arm", v, 32'h1);
    bwi(OFS_KEY, KEY_ARM_A);
    bwi(OFS_KEY, KEY_DIS_A);
    bwi(OFS_KEY, KEY_ARM_B);
    settle();
    br(OFS_STAT, v); chk(v[1] == 1'b0, "R5 mixed keys block arm", v, 32'h1);
    arm();
    bwi(OFS_KEY, KEY_DIS_A);
    bwi(OFS_KEY, 32'h0);
    bwi(OFS_KEY, KEY_DIS_B);
    settle();
    br(OFS_STAT, v); chk(v[1] == 1'b1, "R5 stray word blocks disarm", v, 32'h3);
    disarm();

    // R7 prescaler sweep over all exponents
    bwi(OFS_LOAD, 32'hFFFF_FFFD);
    for (int p = 0; p < 8; p++) begin
      bwi(OFS_CTRL, (32'd1 << 5) | (32'(p) << 2));
      kick();
      arm();
      wait_pulses(2);
      chk(last_rst - prev_rst == (3 << p), $sformatf("R7 R8 interval ptv=%0d", p),
          last_rst - prev_rst, 3 << p);
      disarm();
    end
    bwi(OFS_CTRL, 32'd3 << 2);
    br(OFS_CTRL, v); chk(v == 32'h0C, "R2 control readback", v, 32'h0C);
    kick();
    arm();
    wait_pulses(2);
    chk(last_rst - prev_rst == 3, "R7 prescaler disabled", last_rst - prev_rst, 3);
    disarm();

    // R9 alternating kicks keep it alive, repeats do not
    bwi(OFS_CTRL, 32'h0);
    bwi(OFS_LOAD, 32'hFFFF_FFD8);
    kick();
    arm();
    kick();
    base = rst_cnt;
    for (int k = 0; k < 8; k++) begin
      kick();
      repeat (15) @(negedge fclk);
    end
    chk(rst_cnt == base, "R9 alternating kicks prevent expiry", rst_cnt, base);
    for (int k = 0; k < 6; k++) begin
      bwi(OFS_TRIG, trig_val);
      repeat (15) @(negedge fclk);
    end
    chk(rst_cnt > base, "R9 repeated value does not reload", rst_cnt, base + 1);
    disarm();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule